// File: doc/BRIEF.md
# Frame Buffer Flip Controller

This block decides which of two frame buffers in external memory the video fetch path reads. Software writes a start address for the even-frame slot and one for the odd-frame slot into shadow registers. Those values reach the fetch path only at the rising edge of vertical sync, so a swap never lands in the middle of a frame. The two slots are normally placed in different memory banks on either side of a 16 MB boundary. While one bank is being scanned out, the other bank is entirely free for drawing.

The block has two modes. In free-running mode it changes slot at every vertical sync, whether or not drawing has finished. In acknowledged mode it keeps the current slot until software raises a flip request, and it then swaps at the next vertical sync. Each swap commits the shadow addresses and gives a one-cycle completion pulse. The bank bit of the displayed address is reported as a status bit.

Top module: `fbuf_flip_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the block shows `base_addr` = 0, `bank_idx` = 0 and `flip_done` = 0. The displayed slot is the even slot, and the latched mode is acknowledged (not free-running).
- R2: `base_addr` changes only in the cycle that follows a rising edge of `vsync`.
- R3: A write with `wr_sel` = 0 loads the even-slot shadow and a write with `wr_sel` = 1 loads the odd-slot shadow. A write has no effect on `base_addr` until a later vsync commit. A write in the same cycle as a vsync edge is not part of that edge's commit.
- R4: In free-running mode, every vsync edge commits both shadows into the active registers and toggles the displayed slot. `base_addr` then shows the active address of the new slot (odd = 1, even = 0).
- R5: In acknowledged mode, a vsync edge with no pending request leaves `base_addr`, `bank_idx` and the displayed slot unchanged, and gives no `flip_done`.
- R6: In acknowledged mode, a vsync edge with a pending request commits both shadows, toggles the slot and clears the request.
- R7: A `flip_req` raised in the same cycle as a vsync edge, or at any later point in the frame, stays pending until the next vsync edge.
- R8: `flip_done` is high for exactly the one cycle after a commit, and at no other time.
- R9: `bank_idx` equals bit `BANK_BIT` (default 24) of `base_addr`.
- R10: The `auto_mode` input is sampled at each vsync edge (1 = free-running). The sampled value governs the decision at the following vsync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Vertical sync level; its rising edge marks the frame boundary |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 1 | Shadow select: 0 even slot, 1 odd slot |
| wr_data | input | ADDR_W | Start address to write |
| auto_mode | input | 1 | Requested mode: 1 free-running, 0 acknowledged |
| flip_req | input | 1 | Software flip request pulse |
| base_addr | output | ADDR_W | Start address the fetch path reads this frame |
| bank_idx | output | 1 | Bank bit of the displayed address |
| flip_done | output | 1 | One-cycle pulse after a commit |

## Verification
The checker assumes that `vsync` is low while reset is asserted and on the cycle reset is released. This keeps its own edge detector in step with the block's. It also assumes that every high phase of `vsync` is followed by at least one low cycle, so two vsync edges are never back to back. The bench drives `vsync` as pulses one to three cycles long, separated by gaps of random length, and holds it low through reset. Writes, flip requests and mode changes are placed at random, including in vsync edge cycles, and never break these assumptions.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic {
      SLOT_EVEN = 1'b0,
      SLOT_ODD  = 1'b1
   } slot_e;

   localparam int unsigned NUM_SLOTS = 2;
   localparam int unsigned SLOT_SEL_W = 1;
endpackage

// File: rtl/fbf_vsync_edge.sv
module fbf_vsync_edge #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic vsync_i,
   output logic edge_o
);
   logic vs_eff;
   logic vs_q;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign vs_eff = ~vsync_i;
      end else begin : g_high
         assign vs_eff = vsync_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) vs_q <= 1'b0;
      else     vs_q <= vs_eff;
   end

   assign edge_o = vs_eff & ~vs_q;
endmodule

// File: rtl/fbf_buf_regs.sv
module fbf_buf_regs #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NSLOT  = 2,
   localparam int unsigned SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [SEL_W-1:0]             wr_sel,
   input  logic [ADDR_W-1:0]            wr_data,
   input  logic                         commit,
   output logic [NSLOT-1:0][ADDR_W-1:0] act_o
);
   logic [NSLOT-1:0][ADDR_W-1:0] shd;

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst) shd[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g))) shd[g] <= wr_data;
         end

         always_ff @(posedge clk) begin
            if (rst)         act_o[g] <= '0;
            else if (commit) act_o[g] <= shd[g];
         end
      end
   endgenerate
endmodule

// File: rtl/fbf_flip_seq.sv
module fbf_flip_seq
   import fbf_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  edge_i,
   input  logic  auto_i,
   input  logic  flip_req_i,
   output logic  commit_o,
   output slot_e slot_o
);
   logic auto_q;
   logic pend_q;

   assign commit_o = edge_i & (auto_q | pend_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         auto_q <= 1'b0;
         pend_q <= 1'b0;
         slot_o <= SLOT_EVEN;
      end else begin
         if (edge_i)   auto_q <= auto_i;
         if (commit_o) slot_o <= slot_e'(~slot_o);
         pend_q <= (pend_q & ~commit_o) | flip_req_i;
      end
   end
endmodule

// File: rtl/fbuf_flip_ctrl.sv
module fbuf_flip_ctrl
   import fbf_pkg::*;
#(
   parameter int unsigned ADDR_W           = 32,
   parameter int unsigned BANK_BIT         = 24,
   parameter bit          VSYNC_ACTIVE_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vsync,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              auto_mode,
   input  logic              flip_req,
   output logic [ADDR_W-1:0] base_addr,
   output logic              bank_idx,
   output logic              flip_done
);
   localparam int unsigned NSLOT = NUM_SLOTS;

   generate
      if (BANK_BIT >= ADDR_W) begin : g_bad_bank
         $error("BANK_BIT must lie inside the address");
      end
      if (ADDR_W < 2) begin : g_bad_width
         $error("ADDR_W too small");
      end
   endgenerate

   logic                         vs_edge;
   logic                         commit;
   slot_e                        slot;
   logic [NSLOT-1:0][ADDR_W-1:0] act;

   fbf_vsync_edge #(.ACTIVE_LOW(VSYNC_ACTIVE_LOW)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .vsync_i (vsync),
      .edge_o  (vs_edge)
   );

   fbf_flip_seq u_seq (
      .clk        (clk),
      .rst        (rst),
      .edge_i     (vs_edge),
      .auto_i     (auto_mode),
      .flip_req_i (flip_req),
      .commit_o   (commit),
      .slot_o     (slot)
   );

   fbf_buf_regs #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .commit  (commit),
      .act_o   (act)
   );

   always_ff @(posedge clk) begin
      if (rst) flip_done <= 1'b0;
      else     flip_done <= commit;
   end

   assign base_addr = act[slot];
   assign bank_idx  = base_addr[BANK_BIT];
endmodule

// File: rtl/fbf_chk.sv
module fbf_chk #(
   parameter int unsigned ADDR_W           = 32,
   parameter bit          VSYNC_ACTIVE_LOW = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              vsync,
   input logic [ADDR_W-1:0] base_addr,
   input logic              bank_idx,
   input logic              flip_done
);
   logic vs_eff;
   logic vs_prev;
   logic vs_rise;

   assign vs_eff = VSYNC_ACTIVE_LOW ? ~vsync : vsync;

   always_ff @(posedge clk) begin
      if (rst) vs_prev <= 1'b0;
      else     vs_prev <= vs_eff;
   end

   assign vs_rise = vs_eff & ~vs_prev;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (base_addr == '0 && !bank_idx && !flip_done));

   // R2
   base_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !vs_rise |=> $stable(base_addr));

   // R8
   done_cause_chk: assert property (@(posedge clk) disable iff (rst)
      flip_done |-> $past(vs_rise));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      flip_done |=> !flip_done);

   // R5
   base_move_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(base_addr) |-> flip_done);

   // R9
   bank_move_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(bank_idx) |-> flip_done);
endmodule

bind fbuf_flip_ctrl fbf_chk #(
   .ADDR_W           (ADDR_W),
   .VSYNC_ACTIVE_LOW (VSYNC_ACTIVE_LOW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .vsync     (vsync),
   .base_addr (base_addr),
   .bank_idx  (bank_idx),
   .flip_done (flip_done)
);

// File: tb/sim_fbuf_flip_ctrl.sv
module sim_fbuf_flip_ctrl;
   localparam int unsigned AW = 32;
   localparam int unsigned BB = 24;

   logic          clk = 1'b0;
   logic          rst;
   logic          vsync;
   logic          wr_en;
   logic          wr_sel;
   logic [AW-1:0] wr_data;
   logic          auto_mode;
   logic          flip_req;
   logic [AW-1:0] base_addr;
   logic          bank_idx;
   logic          flip_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // reference model state
   logic [AW-1:0] m_shd [2];
   logic [AW-1:0] m_act [2];
   logic          m_slot, m_pend, m_auto, m_vq, m_done;

   always #5 clk = ~clk;

   fbuf_flip_ctrl #(.ADDR_W(AW), .BANK_BIT(BB)) u0 (
      .clk(clk), .rst(rst), .vsync(vsync), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .auto_mode(auto_mode), .flip_req(flip_req),
      .base_addr(base_addr), .bank_idx(bank_idx), .flip_done(flip_done)
   );

   function automatic logic [AW-1:0] exp_base();
      return m_act[m_slot];
   endfunction

   task automatic model_update();
      logic edge_now, commit;
      if (rst) begin
         m_shd[0] = '0; m_shd[1] = '0; m_act[0] = '0; m_act[1] = '0;
         m_slot = 1'b0; m_pend = 1'b0; m_auto = 1'b0; m_vq = 1'b0; m_done = 1'b0;
      end else begin
         edge_now = vsync & ~m_vq;
         commit   = edge_now & (m_auto | m_pend);
         if (commit) begin
            m_act[0] = m_shd[0];
            m_act[1] = m_shd[1];
            m_slot   = ~m_slot;
         end
         m_pend = (m_pend & ~commit) | flip_req;
         if (edge_now) m_auto = auto_mode;
         if (wr_en) m_shd[wr_sel] = wr_data;
         m_done = commit;
         m_vq   = vsync;
      end
   endtask

   task automatic compare(input string tag);
      n_checks++;
      if (base_addr !== exp_base()) begin
         n_fail++;
         $display("FAIL %s base_addr actual %h expected %h", tag, base_addr, exp_base());
      end
      n_checks++;
      if (bank_idx !== exp_base()[BB]) begin
         n_fail++;
         $display("FAIL R9 (%s) bank_idx actual %b expected %b", tag, bank_idx, exp_base()[BB]);
      end
      n_checks++;
      if (flip_done !== m_done) begin
         n_fail++;
         $display("FAIL R8 (%s) flip_done actual %b expected %b", tag, flip_done, m_done);
      end
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare(tag);
      wr_en    = 1'b0;
      flip_req = 1'b0;
   endtask

   task automatic vsync_pulse(input string tag);
      vsync = 1'b1;
      step(tag);
      vsync = 1'b0;
      step(tag);
   endtask

   task automatic write_shadow(input logic sel, input logic [AW-1:0] d, input string tag);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step(tag);
   endtask

   // directed value checks against literal expectations
   task automatic expect_base(input logic [AW-1:0] e, input string tag);
      n_checks++;
      if (base_addr !== e) begin
         n_fail++;
         $display("FAIL %s base_addr actual %h expected %h", tag, base_addr, e);
      end
   endtask

   initial begin
      int unsigned vs_hi;
      int unsigned vs_gap;
      void'($urandom(32'd20240117));
      rst = 1'b1; vsync = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
      auto_mode = 1'b0; flip_req = 1'b0;
      @(negedge clk);
      step("R1");
      step("R1");
      rst = 1'b0;
      step("R1");
      expect_base('0, "R1");

      // R3: shadow writes do not reach the output before vsync
      write_shadow(1'b0, 32'h0000_1000, "R3");
      write_shadow(1'b1, 32'h0100_2000, "R3");
      step("R3");
      expect_base('0, "R3");

      // R5: acknowledged mode, vsync with nothing pending
      vsync_pulse("R5");
      expect_base('0, "R5");

      // R6: request then vsync -> slot goes odd
      flip_req = 1'b1;
      step("R6");
      step("R6");
      vsync_pulse("R6");
      expect_base(32'h0100_2000, "R6");

      // R7: request in the same cycle as the vsync edge waits a frame
      write_shadow(1'b0, 32'h0000_3000, "R3");
      vsync = 1'b1; flip_req = 1'b1;
      step("R7");
      vsync = 1'b0;
      step("R7");
      expect_base(32'h0100_2000, "R7");
      vsync_pulse("R7");
      expect_base(32'h0000_3000, "R7");

      // R10: mode sampled at one edge, acts at the next
      auto_mode = 1'b1;
      vsync_pulse("R10");
      expect_base(32'h0000_3000, "R10");
      vsync_pulse("R4");
      expect_base(32'h0100_2000, "R4");

      // R4: free-running alternation; write in edge cycle lands later (R3)
      vsync = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0000_5000;
      step("R3");
      vsync = 1'b0;
      step("R4");
      expect_base(32'h0000_3000, "R3");
      vsync_pulse("R4");
      vsync_pulse("R4");
      expect_base(32'h0000_5000, "R4");
      auto_mode = 1'b0;

      // constrained random phase
      vs_hi = 0;
      vs_gap = 5;
      for (int i = 0; i < 20000; i++) begin
         if (vs_hi > 0) begin
            vsync = 1'b1; vs_hi--;
         end else if (vs_gap > 0) begin
            vsync = 1'b0; vs_gap--;
         end else begin
            vsync = 1'b1;
            vs_hi = $urandom_range(2, 0);
            vs_gap = $urandom_range(40, 1);
         end
         wr_en    = ($urandom_range(3, 0) == 0);
         wr_sel   = 1'($urandom_range(1, 0));
         wr_data  = $urandom;
         flip_req = ($urandom_range(14, 0) == 0);
         if ($urandom_range(199, 0) == 0) auto_mode = ~auto_mode;
         step("R2");
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule